// File: doc/BRIEF.md
# NAND Flash Block Erase Sequencer

This block is a host-side controller that erases one flash block through a byte-wide NAND bus. The system presents a 12-bit block number on a valid/ready request port. The sequencer then runs the full erase handshake with one strobe per bus state. It issues the erase-setup command, three row-address bytes and the erase-confirm command. Next it waits out the delay before the device asserts busy, and polls the ready/busy line under a programmable timeout. Last, it issues a status-read command, reads one status byte, and returns a one-cycle completion pulse with a fail flag.

Each bus cycle runs in two phases: a strobe-low phase and a strobe-high phase, each lasting `STROBE_CLKS` clocks. The latch-enable lines and the driven data stay stable across the rising edge of the strobe. The ready/busy input passes through a synchronizer before it is used. The three row bytes carry only the block bits. The five page bits below them are always sent as zero.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset, `req_ready`=1, `nand_we_n`=1, `nand_re_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_dq_oe`=0, `done`=0.
- R2: A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the completion pulse.
- R3: The first bus write of an erase is command byte 60h, latched with `nand_cle`=1 and `nand_ale`=0 on the rising edge of `nand_we_n`.
- R4: Exactly three address writes follow, with `nand_ale`=1 and `nand_cle`=0. For block number B they carry, in this order, {B[2:0],5'b00000}, B[10:3] and {7'b0,B[11]}.
- R5: The confirm command D0h comes right after the third address byte, with no other bus write in between. No erase is started without both 60h and D0h.
- R6: `nand_rb_n` is ignored for `WAIT_MIN` clocks after the confirm cycle ends. The status command is issued only after `nand_rb_n` has returned high.
- R7: After busy ends, command 70h is written, followed by exactly one read cycle with `nand_re_n` low. `nand_dq_oe` is 0 whenever `nand_re_n` is low.
- R8: `done` is a one-cycle pulse. With it, `fail` equals bit 0 of the status byte (1 = fail). Bits 7:1 of the status byte have no effect.
- R9: If `nand_rb_n` stays low for more than `busy_timeout` polling clocks, `done` pulses with `fail`=1 and `timed_out`=1, and no status command is issued. A normal completion reports `timed_out`=0.
- R10: `nand_we_n` and `nand_re_n` are never low together, and `nand_cle` and `nand_ale` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Erase request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_block | input | 12 | Block number to erase |
| busy_timeout | input | TO_W | Maximum polling clocks while busy |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Erase failed or timed out (valid with done) |
| timed_out | output | 1 | Busy wait exceeded the timeout (valid with done) |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven onto the bus |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Byte read from the bus |
| nand_rb_n | input | 1 | Ready (1) / busy (0) from the device |

## Verification
On every cycle, the assertions check strobe and latch exclusivity, that data and latch lines hold across each strobe rise, and the release of the data bus during reads. They also check the single-cycle completion pulse, that a timeout always reports fail, and that ready cannot be seen before the minimum hold has passed. Only the bench scenarios can show the rest. These are the exact byte order and bit placement of the block number in the three address cycles, that the confirm command follows the last address byte, that the status command waits for the device to return ready, and that status bits other than bit 0 are ignored. The bench sweeps one-hot and patterned block numbers against arithmetically derived address bytes.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

    localparam int BLK_W      = 12;
    localparam int PAGE_BITS  = 5;
    localparam int ROW_BYTES  = 3;
    localparam int ROW_W      = ROW_BYTES * 8;

    localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
    localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
    localparam logic [7:0] CMD_READ_STATUS = 8'h70;

    typedef enum logic [1:0] {
        BUS_CMD,
        BUS_ADDR,
        BUS_READ
    } bus_kind_e;

    typedef struct packed {
        bus_kind_e  kind;
        logic [7:0] data;
    } bus_op_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ADDR,
        ST_CONFIRM,
        ST_WAIT,
        ST_STATUS_CMD,
        ST_STATUS_RD
    } seq_state_e;

    // Row address: page bits forced to zero, block bits above them.
    function automatic logic [7:0] row_byte(input logic [BLK_W-1:0] blk,
                                            input logic [1:0] idx);
        logic [ROW_W-1:0] row;
        row = ROW_W'({blk, {PAGE_BITS{1'b0}}});
        case (idx)
            2'd0:    return row[7:0];
            2'd1:    return row[15:8];
            default: return row[23:16];
        endcase
    endfunction

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
    import nand_erase_pkg::*;
#(
    parameter int STROBE_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  bus_op_t    op,
    input  logic [7:0] dq_in,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    output logic [7:0] rd_data,
    output logic       finish
);

    localparam int CW = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STROBE_CLKS - 1);

    typedef enum logic [1:0] {C_IDLE, C_LOW, C_HIGH} cyc_state_e;

    cyc_state_e  cst;
    logic [CW-1:0] cnt;
    bus_kind_e   kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cst     <= C_IDLE;
            cnt     <= '0;
            kind_q  <= BUS_CMD;
            cle     <= 1'b0;
            ale     <= 1'b0;
            we_n    <= 1'b1;
            re_n    <= 1'b1;
            dq_out  <= '0;
            dq_oe   <= 1'b0;
            rd_data <= '0;
            finish  <= 1'b0;
        end else begin
            finish <= 1'b0;
            case (cst)
                C_IDLE: begin
                    if (start) begin
                        kind_q <= op.kind;
                        cle    <= (op.kind == BUS_CMD);
                        ale    <= (op.kind == BUS_ADDR);
                        we_n   <= (op.kind == BUS_READ);
                        re_n   <= (op.kind != BUS_READ);
                        dq_out <= op.data;
                        dq_oe  <= (op.kind != BUS_READ);
                        cnt    <= '0;
                        cst    <= C_LOW;
                    end
                end
                C_LOW: begin
                    if (cnt == LAST) begin
                        we_n <= 1'b1;
                        re_n <= 1'b1;
                        if (kind_q == BUS_READ) rd_data <= dq_in;
                        cnt  <= '0;
                        cst  <= C_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                C_HIGH: begin
                    if (cnt == LAST) begin
                        cle    <= 1'b0;
                        ale    <= 1'b0;
                        dq_oe  <= 1'b0;
                        finish <= 1'b1;
                        cst    <= C_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cst <= C_IDLE;
            endcase
        end
    end

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));
    p_latch_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));
    p_read_released_r7: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> !dq_oe);
    p_hold_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> ($stable(dq_out) && $stable(cle) && $stable(ale)));

endmodule

// File: rtl/nand_busy_wait.sv
module nand_busy_wait #(
    parameter int WAIT_MIN    = 4,
    parameter int TO_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            arm,
    input  logic            rb_n,
    input  logic [TO_W-1:0] busy_timeout,
    output logic            ready_pulse,
    output logic            timeout_pulse
);

    localparam int HW = (WAIT_MIN > 1) ? $clog2(WAIT_MIN) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(WAIT_MIN - 1);
    localparam int KW = $clog2(WAIT_MIN + 2);
    localparam logic [KW-1:0] K_CAP = KW'(WAIT_MIN + 1);

    typedef enum logic [1:0] {W_IDLE, W_HOLD, W_POLL} wait_state_e;

    wait_state_e           wst;
    logic [HW-1:0]         hold_cnt;
    logic [TO_W-1:0]       poll_cnt;
    logic [SYNC_STAGES-1:0] rb_sh;
    logic                  rb_sync;

    always_ff @(posedge clk) begin
        if (rst) rb_sh <= '1;
        else     rb_sh <= {rb_sh[SYNC_STAGES-2:0], rb_n};
    end
    assign rb_sync = rb_sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            wst           <= W_IDLE;
            hold_cnt      <= '0;
            poll_cnt      <= '0;
            ready_pulse   <= 1'b0;
            timeout_pulse <= 1'b0;
        end else begin
            ready_pulse   <= 1'b0;
            timeout_pulse <= 1'b0;
            case (wst)
                W_IDLE: begin
                    if (arm) begin
                        hold_cnt <= '0;
                        wst      <= W_HOLD;
                    end
                end
                W_HOLD: begin
                    if (hold_cnt == HOLD_LAST) begin
                        poll_cnt <= '0;
                        wst      <= W_POLL;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                W_POLL: begin
                    if (rb_sync) begin
                        ready_pulse <= 1'b1;
                        wst         <= W_IDLE;
                    end else if (poll_cnt >= busy_timeout) begin
                        timeout_pulse <= 1'b1;
                        wst           <= W_IDLE;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                default: wst <= W_IDLE;
            endcase
        end
    end

    // Checker-side counter of clocks since arming, saturating above WAIT_MIN.
    logic [KW-1:0] since_arm;
    always_ff @(posedge clk) begin
        if (rst)                    since_arm <= K_CAP;
        else if (arm)               since_arm <= '0;
        else if (since_arm != K_CAP) since_arm <= since_arm + 1'b1;
    end

    p_min_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ready_pulse |-> (since_arm >= KW'(WAIT_MIN)));
    p_poll_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (wst == W_POLL) |-> (poll_cnt <= busy_timeout));
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
        !(ready_pulse && timeout_pulse));

endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
    import nand_erase_pkg::*;
#(
    parameter int STROBE_CLKS = 2,
    parameter int WAIT_MIN    = 4,
    parameter int TO_W        = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BLK_W-1:0] req_block,
    input  logic [TO_W-1:0]  busy_timeout,
    output logic             done,
    output logic             fail,
    output logic             timed_out,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_in,
    input  logic             nand_rb_n
);

    localparam logic [1:0] ADDR_LAST = 2'(ROW_BYTES - 1);

    seq_state_e       state;
    logic [BLK_W-1:0] blk_q;
    logic [1:0]       addr_idx;
    logic             bus_start;
    bus_op_t          bus_op;
    logic             bus_finish;
    logic [7:0]       rd_data;
    logic             arm;
    logic             ready_pulse;
    logic             timeout_pulse;
    logic             unused_status_bits;

    assign unused_status_bits = ^rd_data[7:1];
    assign req_ready = (state == ST_IDLE);

    nand_bus_cycle #(.STROBE_CLKS(STROBE_CLKS)) u_cycle (
        .clk     (clk),
        .rst     (rst),
        .start   (bus_start),
        .op      (bus_op),
        .dq_in   (nand_dq_in),
        .cle     (nand_cle),
        .ale     (nand_ale),
        .we_n    (nand_we_n),
        .re_n    (nand_re_n),
        .dq_out  (nand_dq_out),
        .dq_oe   (nand_dq_oe),
        .rd_data (rd_data),
        .finish  (bus_finish)
    );

    nand_busy_wait #(.WAIT_MIN(WAIT_MIN), .TO_W(TO_W)) u_wait (
        .clk           (clk),
        .rst           (rst),
        .arm           (arm),
        .rb_n          (nand_rb_n),
        .busy_timeout  (busy_timeout),
        .ready_pulse   (ready_pulse),
        .timeout_pulse (timeout_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            blk_q     <= '0;
            addr_idx  <= '0;
            bus_start <= 1'b0;
            bus_op    <= '{kind: BUS_CMD, data: 8'h00};
            arm       <= 1'b0;
            done      <= 1'b0;
            fail      <= 1'b0;
            timed_out <= 1'b0;
        end else begin
            bus_start <= 1'b0;
            arm       <= 1'b0;
            done      <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        blk_q     <= req_block;
                        bus_op    <= '{kind: BUS_CMD, data: CMD_ERASE_SETUP};
                        bus_start <= 1'b1;
                        state     <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (bus_finish) begin
                        addr_idx  <= '0;
                        bus_op    <= '{kind: BUS_ADDR, data: row_byte(blk_q, 2'd0)};
                        bus_start <= 1'b1;
                        state     <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (bus_finish) begin
                        bus_start <= 1'b1;
                        if (addr_idx == ADDR_LAST) begin
                            bus_op <= '{kind: BUS_CMD, data: CMD_ERASE_GO};
                            state  <= ST_CONFIRM;
                        end else begin
                            bus_op   <= '{kind: BUS_ADDR,
                                          data: row_byte(blk_q, addr_idx + 2'd1)};
                            addr_idx <= addr_idx + 2'd1;
                        end
                    end
                end
                ST_CONFIRM: begin
                    if (bus_finish) begin
                        arm   <= 1'b1;
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (timeout_pulse) begin
                        done      <= 1'b1;
                        fail      <= 1'b1;
                        timed_out <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (ready_pulse) begin
                        bus_op    <= '{kind: BUS_CMD, data: CMD_READ_STATUS};
                        bus_start <= 1'b1;
                        state     <= ST_STATUS_CMD;
                    end
                end
                ST_STATUS_CMD: begin
                    if (bus_finish) begin
                        bus_op    <= '{kind: BUS_READ, data: 8'h00};
                        bus_start <= 1'b1;
                        state     <= ST_STATUS_RD;
                    end
                end
                ST_STATUS_RD: begin
                    if (bus_finish) begin
                        done      <= 1'b1;
                        fail      <= rd_data[0];
                        timed_out <= 1'b0;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_timeout_fails_r9: assert property (@(posedge clk) disable iff (rst)
        (done && timed_out) |-> fail);
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    p_confirm_follows_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONFIRM) |-> ($past(state) == ST_CONFIRM || $past(state) == ST_ADDR));
    p_status_after_ready_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STATUS_CMD && $past(state) == ST_WAIT) |-> $past(ready_pulse));

endmodule

// File: tb/sim_nand_erase_seq.sv
module sim_nand_erase_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_block = '0;
    logic [15:0] busy_timeout = 16'd1000;
    logic        done, fail, timed_out;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = 8'h00;
    logic        nand_rb_n = 1'b1;

    always #4 clk = ~clk;

    nand_erase_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_block(req_block), .busy_timeout(busy_timeout), .done(done),
        .fail(fail), .timed_out(timed_out), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
    );

    int checks = 0;
    int errors = 0;

    // Device model state
    logic       log_cle [256];
    logic       log_ale [256];
    logic [7:0] log_byte[256];
    int         n_wr = 0;
    int         n_rd = 0;
    int         strobe_viol = 0;
    int         oe_viol = 0;
    int         busy_cd = 0;
    int         busy_left = 0;
    int         busy_len = 10;
    logic [7:0] status_val = 8'h00;
    logic       status_ok = 1'b0;
    logic       prev_we = 1'b1;
    logic       prev_re = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (!nand_we_n && !nand_re_n) strobe_viol++;
            if (nand_cle && nand_ale)     strobe_viol++;
            if (!nand_re_n && nand_dq_oe) oe_viol++;
            if (!prev_we && nand_we_n) begin
                if (n_wr < 256) begin
                    log_cle[n_wr]  = nand_cle;
                    log_ale[n_wr]  = nand_ale;
                    log_byte[n_wr] = nand_dq_out;
                end
                n_wr++;
                if (nand_cle && nand_dq_out == 8'hD0) begin
                    busy_cd   = 2;
                    busy_left = busy_len;
                end
                if (nand_cle && nand_dq_out == 8'h70)
                    status_ok = (busy_cd == 0) && (busy_left == 0) && nand_rb_n;
            end
            if (!prev_re && nand_re_n) n_rd++;
            nand_dq_in = nand_re_n ? 8'h00 : status_val;
            if (busy_cd > 0) begin
                busy_cd--;
                if (busy_cd == 0) nand_rb_n = 1'b0;
            end else if (!nand_rb_n) begin
                if (busy_left > 0) busy_left--;
                if (busy_left == 0) nand_rb_n = 1'b1;
            end
            prev_we = nand_we_n;
            prev_re = nand_re_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_erase(input logic [11:0] blk, input logic [7:0] stat,
                             input int blen, input logic [15:0] tout,
                             input bit expect_to);
        int base_wr;
        int base_rd;
        int cyc;
        bit got;
        logic got_fail, got_to;
        logic [7:0] exp_b [3];
        base_wr = n_wr;
        base_rd = n_rd;
        status_val   = stat;
        busy_len     = blen;
        busy_timeout = tout;
        status_ok    = 1'b0;
        exp_b[0] = 8'((blk * 32) & 255);
        exp_b[1] = 8'((blk >> 3) & 255);
        exp_b[2] = 8'(blk >> 11);
        @(negedge clk);
        req_block = blk;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
        got = 0;
        got_fail = 0;
        got_to = 0;
        for (int i = 0; i < 20000 && !got; i++) begin
            @(negedge clk);
            if (done) begin
                got = 1;
                got_fail = fail;
                got_to = timed_out;
            end else if (!req_ready) begin
                cyc = i;
            end
        end
        check(got, "R2 watchdog completion", got, 1);
        if (!got) return;
        check(req_ready == 1'b1, "R2 ready with done", req_ready, 1);
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", done, 0);
        // R3 setup command
        check(log_cle[base_wr] && !log_ale[base_wr] && log_byte[base_wr] == 8'h60,
              "R3 setup 60h", log_byte[base_wr], 8'h60);
        // R4 three address bytes
        for (int k = 0; k < 3; k++)
            check(log_ale[base_wr+1+k] && !log_cle[base_wr+1+k]
                  && log_byte[base_wr+1+k] == exp_b[k],
                  "R4 address byte", log_byte[base_wr+1+k], exp_b[k]);
        // R5 confirm right after
        check(log_cle[base_wr+4] && log_byte[base_wr+4] == 8'hD0,
              "R5 confirm D0h", log_byte[base_wr+4], 8'hD0);
        if (expect_to) begin
            check(got_to == 1'b1 && got_fail == 1'b1, "R9 timeout flags",
                  {got_to, got_fail}, 3);
            check(n_wr - base_wr == 5, "R9 no status command", n_wr - base_wr, 5);
            check(n_rd - base_rd == 0, "R9 no read cycle", n_rd - base_rd, 0);
        end else begin
            check(n_wr - base_wr == 6, "R7 write count", n_wr - base_wr, 6);
            check(log_cle[base_wr+5] && log_byte[base_wr+5] == 8'h70,
                  "R7 status 70h", log_byte[base_wr+5], 8'h70);
            check(n_rd - base_rd == 1, "R7 one read", n_rd - base_rd, 1);
            check(status_ok, "R6 status after ready", status_ok, 1);
            check(got_fail == stat[0], "R8 fail is status bit0", got_fail, stat[0]);
            check(got_to == 1'b0, "R9 no timeout flag", got_to, 0);
        end
        // let device model go idle
        for (int i = 0; i < 2000 && !(busy_cd == 0 && nand_rb_n); i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] stats [4];
        stats[0] = 8'hE0; stats[1] = 8'hE1; stats[2] = 8'hFE; stats[3] = 8'h01;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && nand_we_n && nand_re_n && !nand_cle && !nand_ale
              && !nand_dq_oe && !done, "R1 reset state",
              {req_ready, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, done},
              7'b1110000);
        run_erase(12'h000, 8'hE0, 8, 16'd1000, 0);
        for (int b = 0; b < 12; b++)
            run_erase(12'(1 << b), stats[b % 4], 5 + 2 * b, 16'd1000, 0);
        run_erase(12'hFFF, 8'hFE, 12, 16'd1000, 0);
        run_erase(12'hA5A, 8'h01, 20, 16'd1000, 0);
        run_erase(12'h5A5, 8'hE0, 30, 16'd1000, 0);
        // R9: busy longer than the timeout, then within a larger one
        run_erase(12'h123, 8'hE0, 100, 16'd10, 1);
        run_erase(12'h321, 8'hE0, 100, 16'd200, 0);
        check(strobe_viol == 0, "R10 strobe/latch exclusivity", strobe_viol, 0);
        check(oe_viol == 0, "R7 bus released on read", oe_viol, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule